// File: doc/BRIEF.md
# Serial Byte Datapath for a Two-Wire Bus Controller

This block is the byte-wide data path of a two-wire serial bus controller running on the bus clock. A single shift register serves both directions. For transmit, the most significant bit goes onto the data line first and the register moves left one place per bit. For receive, each sampled bit enters at the least significant end. A three-bit counter tracks progress through the byte, and a one-cycle flag marks the end of each byte.

Software reaches the block through write strobes for the shift register and for a staging buffer, and through read strobes. All writes are gated by an enable input. A write to the shift register while in master mode asks the clock generator to start toggling the clock line for that byte. A write to the staging buffer loads the same byte into the shift register without starting the clock, so an address can be staged ahead of a repeated start. A spacing unit holds off start requests that come too soon after a buffer write, and holds off all clock starts for a fixed window after master mode is dropped.

Top module: `i2c_byte_path`

## Requirements
- R1: After an enabled write of data D (shift register or buffer), `sda_out` equals D[7]; after the k-th `scl_fall` of the byte (k = 1..7) it equals D[7-k].
- R2: Each `scl_rise` while a byte is in progress shifts the register left and places `sda_in` at bit 0; after eight rises a shift register read returns the eight sampled bits, first sampled bit in bit 7.
- R3: Writes to either register are ignored while `en` is 0; a shift register read (`shreg_rd` = 1, `buf_rd` = 0) returns the register contents whatever `en` is.
- R4: Any enabled write restarts the bit count, so `byte_done` follows the eighth `scl_rise` after the most recent write.
- R5: An enabled shift register write with `master` = 1 raises `scl_go` for one cycle in the next cycle, unless held off by R8.
- R6: A buffer write loads the shift register (readable, and driving `sda_out` per R1) but never raises `scl_go`; a read with `buf_rd` = 1 returns 8'h00.
- R7: A `start_req` at the same edge as a buffer write or one cycle after it raises `start_early` for one cycle in the next cycle, and `start_grant` is then given no earlier than two cycles after the buffer write; a request two or more cycles later is granted in the next cycle with no `start_early`.
- R8: After `master` falls from 1 to 0, `scl_go` and `start_grant` stay low for 20 cycles; requests made in that window are served on the 20th edge after the fall.
- R9: `sda_out` is 1 (released) while `en` is 0 and after the eighth `scl_fall` of a byte.
- R10: `byte_done` is high for exactly one cycle, in the cycle after the eighth `scl_rise` of a byte.
- R11: While `en` is 0 the register does not shift and the bit count sits at 0; no byte completes until a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; gates writes and shifting |
| master | input | 1 | Master mode select |
| scl_rise | input | 1 | One-cycle strobe at each clock line rising edge |
| scl_fall | input | 1 | One-cycle strobe at each clock line falling edge |
| sda_in | input | 1 | Sampled data line level |
| shreg_wr | input | 1 | Shift register write strobe |
| buf_wr | input | 1 | Staging buffer write strobe |
| wdata | input | 8 | Write data |
| shreg_rd | input | 1 | Shift register read select |
| buf_rd | input | 1 | Staging buffer read select |
| start_req | input | 1 | Start or repeated start request |
| rdata | output | 8 | Read data |
| sda_out | output | 1 | Open-drain data drive, 1 releases the line |
| scl_go | output | 1 | One-cycle request to begin clocking a byte |
| start_grant | output | 1 | One-cycle permission to issue a start |
| start_early | output | 1 | One-cycle flag for a start request made too soon |
| byte_done | output | 1 | One-cycle byte-complete pulse |

## Verification
A corrupted bit count shows at the ports as `byte_done` firing on the wrong rise, one rise after the error at the earliest, and a wrong shift shows in `sda_out` at the very next `scl_fall` or in the byte read back after completion. A stuck or mis-loaded spacing counter shows as `scl_go` or `start_grant` appearing on an edge other than the 20th after a master drop, or a start granted one cycle after a buffer write, so the bench checks those outputs on every edge of each window rather than only at its end.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned START_GAP = 2;
    localparam int unsigned MST_HOLD  = 20;

    typedef struct packed {
        logic load;
        logic go_scl;
    } acc_t;

    function automatic int unsigned ctr_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/i2cb_shifter.sv
module i2cb_shifter
    import i2cb_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    input  logic         scl_rise,
    input  logic         scl_fall,
    input  logic         sda_in,
    output logic [W-1:0] sr_q,
    output logic         sda_out,
    output logic         byte_done
);
    localparam int unsigned CW = ctr_bits(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic          act_q;
    logic          sda_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            act_q  <= 1'b0;
            sda_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!en) begin
                cnt_q <= '0;
                act_q <= 1'b0;
                sda_q <= 1'b1;
            end else if (load) begin
                sr_q  <= ld_data;
                cnt_q <= '0;
                act_q <= 1'b1;
                sda_q <= ld_data[W-1];
            end else begin
                if (scl_rise && act_q) begin
                    sr_q  <= {sr_q[W-2:0], sda_in};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
                if (scl_fall) begin
                    sda_q <= act_q ? sr_q[W-1] : 1'b1;
                end
            end
        end
    end

    assign sda_out   = sda_q;
    assign byte_done = done_q;

    // R1: an enabled load puts its top bit on the line next cycle
    p_load_msb_r1: assert property (@(posedge clk) disable iff (rst)
        (en && load) |=> (sda_out == $past(ld_data[W-1])));

    // R9: line released while disabled
    p_idle_release_r9: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> sda_out);

    // R11: register frozen while disabled
    p_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        (!rst && !en) |=> $stable(sr_q));

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> !byte_done);

endmodule

// File: rtl/i2cb_spacing.sv
module i2cb_spacing
    import i2cb_pkg::*;
#(
    parameter int unsigned GAP  = START_GAP,
    parameter int unsigned HOLD = MST_HOLD
) (
    input  logic clk,
    input  logic rst,
    input  logic master,
    input  logic scl_req,
    input  logic buf_load,
    input  logic start_req,
    output logic scl_go,
    output logic start_grant,
    output logic start_early
);
    localparam int unsigned HW = ctr_bits(HOLD + 1);
    localparam int unsigned GW = ctr_bits(GAP + 1);
    localparam logic [HW-1:0] HOLD_LD = HW'(HOLD - 1);
    localparam logic [GW-1:0] GAP_LD  = GW'(GAP - 1);

    logic          mst_q;
    logic [HW-1:0] hold_cnt;
    logic [GW-1:0] gap_cnt;
    logic          scl_pend, st_pend;
    logic          go_q, grant_q, early_q;

    logic mst_fall, hold_blk, gap_blk, want_scl, want_st;

    always_comb begin
        mst_fall = mst_q && !master;
        hold_blk = mst_fall || (hold_cnt != '0);
        gap_blk  = buf_load || (gap_cnt != '0);
        want_scl = scl_pend || scl_req;
        want_st  = st_pend || start_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mst_q    <= 1'b0;
            hold_cnt <= '0;
            gap_cnt  <= '0;
            scl_pend <= 1'b0;
            st_pend  <= 1'b0;
            go_q     <= 1'b0;
            grant_q  <= 1'b0;
            early_q  <= 1'b0;
        end else begin
            mst_q <= master;

            if (mst_fall)             hold_cnt <= HOLD_LD;
            else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;

            if (buf_load)             gap_cnt <= GAP_LD;
            else if (gap_cnt != '0)   gap_cnt <= gap_cnt - 1'b1;

            if (want_scl && !hold_blk) begin
                go_q     <= 1'b1;
                scl_pend <= 1'b0;
            end else begin
                go_q     <= 1'b0;
                scl_pend <= want_scl;
            end

            early_q <= start_req && gap_blk;
            if (want_st && !gap_blk && !hold_blk) begin
                grant_q <= 1'b1;
                st_pend <= 1'b0;
            end else begin
                grant_q <= 1'b0;
                st_pend <= want_st;
            end
        end
    end

    assign scl_go      = go_q;
    assign start_grant = grant_q;
    assign start_early = early_q;

    // R8: a master drop blocks clock start and start grant at once
    p_fall_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(master) |=> (!scl_go && !start_grant));

    // R7: a request flagged early is not granted in the same cycle
    p_early_no_grant_r7: assert property (@(posedge clk) disable iff (rst)
        start_early |-> !start_grant);

endmodule

// File: rtl/i2c_byte_path.sv
module i2c_byte_path
    import i2cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              master,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic              shreg_wr,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              shreg_rd,
    input  logic              buf_rd,
    input  logic              start_req,
    output logic [BYTE_W-1:0] rdata,
    output logic              sda_out,
    output logic              scl_go,
    output logic              start_grant,
    output logic              start_early,
    output logic              byte_done
);
    acc_t              acc;
    logic              buf_ok;
    logic [BYTE_W-1:0] sr_val;

    always_comb begin
        buf_ok     = en && buf_wr;
        acc.load   = en && (shreg_wr || buf_wr);
        acc.go_scl = en && shreg_wr && master;
        rdata      = (shreg_rd && !buf_rd) ? sr_val : '0;
    end

    i2cb_shifter #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .load      (acc.load),
        .ld_data   (wdata),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_in    (sda_in),
        .sr_q      (sr_val),
        .sda_out   (sda_out),
        .byte_done (byte_done)
    );

    i2cb_spacing #(.GAP(START_GAP), .HOLD(MST_HOLD)) u_space (
        .clk         (clk),
        .rst         (rst),
        .master      (master),
        .scl_req     (acc.go_scl),
        .buf_load    (buf_ok),
        .start_req   (start_req),
        .scl_go      (scl_go),
        .start_grant (start_grant),
        .start_early (start_early)
    );

    // R6: buffer reads expose nothing
    p_buf_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        buf_rd |-> (rdata == '0));

endmodule

// File: tb/test_i2c_byte_path.sv
module test_i2c_byte_path;
    logic       clk = 1'b0;
    logic       rst, en, master, scl_rise, scl_fall, sda_in;
    logic       shreg_wr, buf_wr, shreg_rd, buf_rd, start_req;
    logic [7:0] wdata, rdata;
    logic       sda_out, scl_go, start_grant, start_early, byte_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    i2c_byte_path i_i2c_byte_path (
        .clk(clk), .rst(rst), .en(en), .master(master),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .shreg_wr(shreg_wr), .buf_wr(buf_wr), .wdata(wdata),
        .shreg_rd(shreg_rd), .buf_rd(buf_rd), .start_req(start_req),
        .rdata(rdata), .sda_out(sda_out), .scl_go(scl_go),
        .start_grant(start_grant), .start_early(start_early),
        .byte_done(byte_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_sr(input logic [7:0] d);
        wdata = d; shreg_wr = 1'b1; step(); shreg_wr = 1'b0;
    endtask

    task automatic wr_buf(input logic [7:0] d);
        wdata = d; buf_wr = 1'b1; step(); buf_wr = 1'b0;
    endtask

    task automatic rise(input logic b);
        sda_in = b; scl_rise = 1'b1; step(); scl_rise = 1'b0;
    endtask

    task automatic fall();
        scl_fall = 1'b1; step(); scl_fall = 1'b0;
    endtask

    task automatic read_sr(output logic [7:0] v);
        shreg_rd = 1'b1; #1 v = rdata; shreg_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("reset sda_out", sda_out, 1);
        chk("reset scl_go", scl_go, 0);
        chk("reset byte_done", byte_done, 0);
        chk("reset start_grant", start_grant, 0);
        read_sr(v);
        chk("reset rdata", v, 0);
    endtask

    task automatic t_txrx();
        logic [7:0] tx = 8'hA5, rx = 8'h3C, v;
        wr_sr(tx);
        chk("R5 scl_go after master write", scl_go, 1);
        for (int i = 7; i >= 0; i--) begin
            chk("R1 tx bit", sda_out, tx[i]);
            rise(rx[i]);
            chk("R10 byte_done timing", byte_done, (i == 0));
            fall();
        end
        chk("R10 byte_done single cycle", byte_done, 0);
        chk("R9 released after byte", sda_out, 1);
        read_sr(v);
        chk("R2 received byte", v, rx);
    endtask

    task automatic t_gate();
        logic [7:0] v;
        en = 1'b0; step();
        wr_sr(8'h12);
        read_sr(v);
        chk("R3 write ignored, read allowed", v, 8'h3C);
        chk("R9 released while disabled", sda_out, 1);
        rise(1'b1);
        chk("R11 no completion while disabled", byte_done, 0);
        fall();
        read_sr(v);
        chk("R11 no shift while disabled", v, 8'h3C);
        en = 1'b1; step();
    endtask

    task automatic t_restart();
        logic [7:0] v;
        wr_sr(8'hFF);
        for (int i = 0; i < 3; i++) begin rise(1'b1); fall(); end
        wr_sr(8'h00);
        for (int i = 0; i < 7; i++) begin
            rise(1'b1);
            chk("R4 count restarted, no early done", byte_done, 0);
            fall();
        end
        rise(1'b1);
        chk("R4 done on eighth rise after rewrite", byte_done, 1);
        fall();
        read_sr(v);
        chk("R2 all ones received", v, 8'hFF);
    endtask

    task automatic t_buffer();
        logic [7:0] v;
        wr_buf(8'h41);
        chk("R6 no scl_go on buffer write", scl_go, 0);
        chk("R1 buffer msb on line", sda_out, 0);
        read_sr(v);
        chk("R6 buffer loads shift register", v, 8'h41);
        buf_rd = 1'b1; #1 v = rdata; buf_rd = 1'b0;
        chk("R6 buffer read returns zero", v, 0);
        step(); step();
    endtask

    task automatic t_gap();
        wr_buf(8'h80);
        start_req = 1'b1; step(); start_req = 1'b0;
        chk("R7 early flag", start_early, 1);
        chk("R7 no grant yet", start_grant, 0);
        step();
        chk("R7 grant after gap", start_grant, 1);
        chk("R7 early flag one cycle", start_early, 0);
        step();
        wr_buf(8'h80);
        step();
        start_req = 1'b1; step(); start_req = 1'b0;
        chk("R7 timely request granted", start_grant, 1);
        chk("R7 timely request not flagged", start_early, 0);
        step();
    endtask

    task automatic t_hold();
        master = 1'b0; step();
        master = 1'b1; wdata = 8'h55; shreg_wr = 1'b1; start_req = 1'b1;
        step();
        shreg_wr = 1'b0; start_req = 1'b0;
        chk("R8 scl_go held after drop", scl_go, 0);
        for (int k = 2; k < 20; k++) begin
            step();
            chk("R8 scl_go held in window", scl_go, 0);
            chk("R8 start held in window", start_grant, 0);
        end
        step();
        chk("R8 scl_go served on 20th edge", scl_go, 1);
        chk("R8 start served on 20th edge", start_grant, 1);
        step();
        chk("R5 scl_go single pulse", scl_go, 0);
        master = 1'b0; step(); step();
        wr_sr(8'h01);
        chk("R5 no scl_go without master", scl_go, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; master = 1'b0; scl_rise = 1'b0; scl_fall = 1'b0;
        sda_in = 1'b0; shreg_wr = 1'b0; buf_wr = 1'b0; wdata = '0;
        shreg_rd = 1'b0; buf_rd = 1'b0; start_req = 1'b0;
        repeat (3) step();
        rst = 1'b0; step();
        t_reset();
        en = 1'b1; master = 1'b1; step();
        t_txrx();
        t_gate();
        t_restart();
        t_buffer();
        t_gap();
        t_hold();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule